// File: doc/BRIEF.md
# Late-Write Pipelined Burst SRAM

This block is a synchronous single-port static memory with a 72-bit word made of eight 9-bit byte lanes. It is built so that the shared data bus never needs a dead cycle between a read and a write. Reads are pipelined: the array is accessed in the cycle after the command and the result comes out of an output register one cycle later. Writes are late: the command and address are taken on one clock edge and the matching data word is sampled two edges later. Because of this, any mix of reads and writes can be issued back to back.

Every rising edge samples the address, a write strobe, eight active-low lane enables, an advance strobe and three chip enables. When advance is low, a new access starts. When advance is high, the current access continues as a burst. In a burst only the two low address bits step, in a linear order that wraps. Two of the chip enables compare against static polarity pins. Four copies can therefore share a bus and decode two address bits into four banks without glue logic. The block drives an output enable for the data bus and an enable for an echo clock driver.

A read whose address still has a write in flight returns the data of that write, merged lane by lane over the older array contents.

Top module: `lwsram_core`

## Requirements
- R1: While reset is high and after it, until a command takes effect, `dout_oe` is 0 and `echo_oe` is 1. The block behaves as deselected with no access in flight. Reset does not clear the array.
- R2: A read command sampled at edge k (`adv`=0, `ce1_n`=0, bank match, `we_n`=1) makes `dout` carry the word at `addr` and `dout_oe`=1 from edge k+1 until edge k+2.
- R3: A write command sampled at edge k stores the `din` value sampled at edge k+2. Only the lanes i with `bw_n[i]`=0 at edge k are stored; lane i is bits [9i+8:9i].
- R4: A write beat with all of `bw_n` high leaves the array unchanged, and the burst address still advances.
- R5: With `adv`=1 during a read or write, the next beat repeats the same operation at an address whose bits [1:0] are incremented modulo 4 and whose upper bits are kept. `addr`, `we_n` and the chip enables are ignored on that beat.
- R6: The bank matches only when `ce2`==`pol2` and `ce3`==`pol3`. A new command without a bank match is a bank deselect, whatever `ce1_n` is. One cycle after such a command `echo_oe` is 0 and `dout_oe` is 0, and the array is untouched.
- R7: A new command with a bank match and `ce1_n`=1 is a deselect. One cycle later `dout_oe` is 0 and `echo_oe` stays 1, and nothing is written even if `we_n` is 0.
- R8: During the output cycle of a write beat or a deselect beat, `dout_oe` is 0.
- R9: `adv`=1 while deselected (either kind) keeps that same deselect state. No address advances and no array access occurs.
- R10: A read of an address written by the command one edge earlier returns that write's `din` in its enabled lanes and the older contents in the others.
- R11: Reads and writes can alternate on consecutive edges with no idle cycle, and each read returns the word produced by all earlier commands in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address of a new access |
| we_n | input | 1 | Low for write, high for read |
| bw_n | input | 8 | Active-low lane write enables |
| adv | input | 1 | High continues the current burst or state |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Bank enable compared with pol2 |
| ce3 | input | 1 | Bank enable compared with pol3 |
| pol2 | input | 1 | Static level that ce2 must equal |
| pol3 | input | 1 | Static level that ce3 must equal |
| din | input | 72 | Write data, due two edges after its command |
| dout | output | 72 | Registered read data |
| dout_oe | output | 1 | Data bus drive enable |
| echo_oe | output | 1 | Echo clock drive enable |

## Verification
The collision that matters happens when a late write's data lands in the array on the very edge at which the output register captures a read of the same address. Then the array write and the read capture fall in one cycle, and the read has to take the incoming lanes from `din` instead of the array. The bench provokes this by issuing a write and then a read of the same address on the next edge, with full, partial and abort lane masks, and by stacking two writes before a read. It judges every returned word against a reference memory that is updated in command issue order.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    localparam int LANES  = 8;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_DESEL   = 2'd0,
        OP_BANKOFF = 2'd1,
        OP_READ    = 2'd2,
        OP_WRITE   = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] lane_we;
    } beat_t;

    function automatic logic [1:0] wrap_step(input logic [1:0] a);
        return a + 2'd1;
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] base,
        input logic [WORD_W-1:0] upd,
        input logic [LANES-1:0]  sel
    );
        logic [WORD_W-1:0] r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (sel[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/lws_ctrl.sv
module lws_ctrl
    import lwsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr_i,
    input  logic             we_n_i,
    input  logic [LANES-1:0] bw_n_i,
    input  logic             adv_i,
    input  logic             ce1_n_i,
    input  logic             ce2_i,
    input  logic             ce3_i,
    input  logic             pol2_i,
    input  logic             pol3_i,
    output beat_t            beat_o,
    output logic [AW-1:0]    addr_o
);

    op_e              cur_op, nxt_op;
    logic [AW-1:0]    cur_addr, nxt_addr;
    logic [LANES-1:0] cur_lanes, nxt_lanes;
    logic             bank_hit;

    assign bank_hit = (ce2_i == pol2_i) && (ce3_i == pol3_i);

    always_comb begin
        nxt_op   = cur_op;
        nxt_addr = cur_addr;
        if (adv_i) begin
            if (cur_op == OP_READ || cur_op == OP_WRITE)
                nxt_addr = {cur_addr[AW-1:2], wrap_step(cur_addr[1:0])};
        end else if (!bank_hit) begin
            nxt_op = OP_BANKOFF;
        end else if (ce1_n_i) begin
            nxt_op = OP_DESEL;
        end else begin
            nxt_op   = we_n_i ? OP_READ : OP_WRITE;
            nxt_addr = addr_i;
        end
        nxt_lanes = (nxt_op == OP_WRITE) ? ~bw_n_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_op    <= OP_DESEL;
            cur_addr  <= '0;
            cur_lanes <= '0;
        end else begin
            cur_op    <= nxt_op;
            cur_addr  <= nxt_addr;
            cur_lanes <= nxt_lanes;
        end
    end

    assign beat_o = '{op: cur_op, lane_we: cur_lanes};
    assign addr_o = cur_addr;

endmodule

// File: rtl/lws_wpipe.sv
module lws_wpipe
    import lwsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             beat_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic [WORD_W-1:0] arr_i,
    output logic [LANES-1:0]  wr_lanes_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [WORD_W-1:0] rd_word_o
);

    logic [LANES-1:0] late_lanes;
    logic [AW-1:0]    late_addr;
    logic [LANES-1:0] fwd_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            late_lanes <= '0;
            late_addr  <= '0;
        end else begin
            late_lanes <= (beat_i.op == OP_WRITE) ? beat_i.lane_we : '0;
            late_addr  <= addr_i;
        end
    end

    assign wr_lanes_o = late_lanes;
    assign wr_addr_o  = late_addr;
    assign fwd_sel    = (late_addr == addr_i) ? late_lanes : '0;
    assign rd_word_o  = lane_merge(arr_i, din_i, fwd_sel);

endmodule

// File: rtl/lws_array.sv
module lws_array
    import lwsram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[g]) store[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = store[raddr_i];
    end

endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
    import lwsram_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              adv,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3,
    input  logic              pol2,
    input  logic              pol3,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe,
    output logic              echo_oe
);

    beat_t             s1_beat;
    logic [AW-1:0]     s1_addr;
    logic [LANES-1:0]  wr_lanes;
    logic [AW-1:0]     wr_addr;
    logic [WORD_W-1:0] arr_word;
    logic [WORD_W-1:0] rd_word;

    lws_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .addr_i(addr), .we_n_i(we_n), .bw_n_i(bw_n),
        .adv_i(adv), .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_i(ce3),
        .pol2_i(pol2), .pol3_i(pol3), .beat_o(s1_beat), .addr_o(s1_addr)
    );

    lws_wpipe #(.AW(AW)) u_wpipe (
        .clk(clk), .rst(rst), .beat_i(s1_beat), .addr_i(s1_addr),
        .din_i(din), .arr_i(arr_word), .wr_lanes_o(wr_lanes),
        .wr_addr_o(wr_addr), .rd_word_o(rd_word)
    );

    lws_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .we_i(wr_lanes), .waddr_i(wr_addr), .wdata_i(din),
        .raddr_i(s1_addr), .rdata_o(arr_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            dout_oe <= 1'b0;
            echo_oe <= 1'b1;
        end else begin
            dout_oe <= (s1_beat.op == OP_READ);
            echo_oe <= (s1_beat.op != OP_BANKOFF);
            if (s1_beat.op == OP_READ) dout <= rd_word;
        end
    end

endmodule

// File: rtl/lws_chk.sv
module lws_chk
    import lwsram_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          adv,
    input logic          we_n,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3,
    input logic          pol2,
    input logic          pol3,
    input logic          dout_oe,
    input logic          echo_oe,
    input op_e           cur_op,
    input logic [AW-1:0] cur_addr
);

    logic hit;
    assign hit = (ce2 == pol2) && (ce3 == pol3);

    p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
        (!adv && hit && !ce1_n && we_n) |=> ##1 dout_oe);

    p_write_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!adv && hit && !ce1_n && !we_n) |=> ##1 (!dout_oe && echo_oe));

    p_bank_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!adv && !hit) |=> ##1 (!echo_oe && !dout_oe));

    p_desel_echo_r7: assert property (@(posedge clk) disable iff (rst)
        (!adv && hit && ce1_n) |=> ##1 (!dout_oe && echo_oe));

    p_burst_step_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && (cur_op == OP_READ || cur_op == OP_WRITE)) |=>
        (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
        (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])) &&
        (cur_op == $past(cur_op)));

    p_desel_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && (cur_op == OP_DESEL || cur_op == OP_BANKOFF)) |=>
        ($stable(cur_addr) && cur_op == $past(cur_op)));

    p_oe_needs_echo_r8: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> echo_oe);

endmodule

bind lwsram_core lws_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .adv(adv), .we_n(we_n), .ce1_n(ce1_n),
    .ce2(ce2), .ce3(ce3), .pol2(pol2), .pol3(pol3),
    .dout_oe(dout_oe), .echo_oe(echo_oe),
    .cur_op(s1_beat.op), .cur_addr(s1_addr)
);

// File: tb/sim_lwsram_core.sv
module sim_lwsram_core;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int W     = 72;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          we_n = 1'b1, adv = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3 = 1'b0;
    logic          pol2 = 1'b0, pol3 = 1'b0;
    logic [7:0]    bw_n = 8'hFF;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;
    logic          dout_oe, echo_oe;

    lwsram_core #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .we_n(we_n), .bw_n(bw_n),
        .adv(adv), .ce1_n(ce1_n), .ce2(ce2), .ce3(ce3), .pol2(pol2),
        .pol3(pol3), .din(din), .dout(dout), .dout_oe(dout_oe),
        .echo_oe(echo_oe)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        int           due;
        bit           oe;
        bit           echo;
        logic [W-1:0] data;
        string        req;
    } exp_t;
    exp_t sbq[$];

    logic [W-1:0] ref_mem [DEPTH];
    logic [W-1:0] dslot [4];
    bit           dvalid [4];
    int           m_op = 0;     // 0 deselect, 1 bank off, 2 read, 3 write
    logic [AW-1:0] m_addr = '0;

    function automatic logic [W-1:0] mkword(input int n);
        return {32'(n * 32'h9E3779B1), 32'(n * 32'h7F4A7C15 + 1), 8'(n)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [W+1:0] act,
                         input logic [W+1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h (oe,echo,data)", req, act, exp);
        end
    endtask

    // monitor: pop expected items as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            while (sbq.size() > 0 && sbq[0].due == cyc) begin
                exp_t e;
                bit ok;
                e  = sbq.pop_front();
                ok = (dout_oe === e.oe) && (echo_oe === e.echo) &&
                     (!e.oe || dout === e.data);
                check(ok, e.req, {dout_oe, echo_oe, dout}, {e.oe, e.echo, e.data});
            end
        end
    end

    // driver: apply one command and push its expected outcome
    task automatic issue(input bit a_adv, input bit a_ce1n, input bit a_ce2,
                         input bit a_ce3, input bit a_wen, input logic [7:0] a_bwn,
                         input logic [AW-1:0] a_addr, input string req);
        int s;
        bit hit;
        logic [W-1:0] w;
        exp_t e;
        @(negedge clk);
        s = cyc % 4;
        din = dvalid[s] ? dslot[s] : ~mkword(cyc + 777);
        dvalid[s] = 0;
        adv = a_adv; ce1_n = a_ce1n; ce2 = a_ce2; ce3 = a_ce3;
        we_n = a_wen; bw_n = a_bwn; addr = a_addr;
        if (a_adv) begin
            if (m_op >= 2) m_addr[1:0] = m_addr[1:0] + 2'd1;
        end else begin
            hit = (a_ce2 == pol2) && (a_ce3 == pol3);
            if (!hit) m_op = 1;
            else if (a_ce1n) m_op = 0;
            else begin
                m_op = a_wen ? 2 : 3;
                m_addr = a_addr;
            end
        end
        if (m_op == 3) begin
            w = mkword(cyc);
            for (int l = 0; l < 8; l++)
                if (!a_bwn[l]) ref_mem[m_addr][l*9 +: 9] = w[l*9 +: 9];
            dslot[(cyc + 2) % 4] = w;
            dvalid[(cyc + 2) % 4] = 1;
        end
        e.due  = cyc + 2;
        e.oe   = (m_op == 2);
        e.echo = (m_op != 1);
        e.data = (m_op == 2) ? ref_mem[m_addr] : '0;
        e.req  = req;
        sbq.push_back(e);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        issue(0, 0, pol2, pol3, 1, 8'hFF, a, req);
    endtask
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] m, input string req);
        issue(0, 0, pol2, pol3, 0, m, a, req);
    endtask
    // continue beat; the other controls are set to values that must be ignored
    task automatic cont(input logic [7:0] m, input string req);
        issue(1, 1, ~pol2, pol3, ~we_n, m, ~addr, req);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(0, 1, pol2, pol3, 1, 8'hFF, '0, "R7");
    endtask

    task automatic do_reset(input bit p2, input bit p3);
        @(negedge clk);
        rst = 1; pol2 = p2; pol3 = p3;
        adv = 0; ce1_n = 1; ce2 = p2; ce3 = p3; we_n = 1; bw_n = 8'hFF;
        repeat (2) @(negedge clk);
        check(dout_oe === 1'b0 && echo_oe === 1'b1, "R1 reset state",
              {dout_oe, echo_oe, dout}, {2'b01, dout});
        sbq.delete();
        for (int i = 0; i < 4; i++) dvalid[i] = 0;
        m_op = 0;
        rst = 0;
    endtask

    initial begin
        do_reset(1, 0);
        idle(2);                                    // R1: stays deselected
        // fill 0..15 with four-beat bursts
        for (int b = 0; b < 4; b++) begin
            wr(AW'(b * 4), 8'h00, "R3");
            for (int j = 0; j < 3; j++) cont(8'h00, "R5");
        end
        // read burst with wrap: 6,7,4,5
        rd(8'd6, "R2");
        for (int j = 0; j < 3; j++) cont(8'h00, "R5 read wrap");
        // partial write burst 9,10,11(abort),8
        wr(8'd9, 8'hF0, "R3");
        cont(8'h0F, "R3");
        cont(8'hFF, "R4");
        cont(8'h5A, "R3");
        rd(8'd8, "R3 lanes");
        for (int j = 0; j < 3; j++) cont(8'hFF, "R4 abort and lanes");
        // back-to-back mix, no idle cycle
        wr(8'd20, 8'h00, "R11");
        rd(8'd1, "R11");
        wr(8'd21, 8'h00, "R11");
        rd(8'd20, "R11");
        rd(8'd21, "R11");
        // forwarding of an in-flight write
        wr(8'd30, 8'h00, "R10");
        rd(8'd30, "R10 full");
        wr(8'd30, 8'h33, "R10");
        rd(8'd30, "R10 merge");
        wr(8'd31, 8'h00, "R10");
        wr(8'd31, 8'hC3, "R10");
        rd(8'd31, "R10 stacked");
        wr(8'd31, 8'hFF, "R4");
        rd(8'd31, "R4 abort forward");
        // deselect and its continuation
        issue(0, 1, pol2, pol3, 0, 8'h00, 8'd1, "R7");
        issue(1, 0, pol2, pol3, 0, 8'h00, 8'd1, "R9");
        issue(1, 0, pol2, pol3, 0, 8'h00, 8'd2, "R9");
        rd(8'd1, "R9");
        rd(8'd2, "R7");
        // bank deselect
        issue(0, 0, ~pol2, pol3, 0, 8'h00, 8'd3, "R6");
        issue(1, 0, pol2, pol3, 0, 8'h00, 8'd3, "R9 bank");
        issue(0, 0, pol2, ~pol3, 1, 8'hFF, 8'd3, "R6");
        rd(8'd3, "R6");
        // read burst 15,12,13,14
        rd(8'd15, "R5");
        for (int j = 0; j < 3; j++) cont(8'h00, "R5");
        idle(3);
        // every polarity setting
        for (int p = 0; p < 4; p++) begin
            do_reset(p[1], p[0]);
            rd(8'd0, "R1 array kept");
            wr(AW'(40 + p), 8'h00, "R6");
            rd(AW'(40 + p), "R6");
            issue(0, 0, ~pol2, pol3, 0, 8'h00, AW'(40 + p), "R6");
            issue(0, 1, pol2, ~pol3, 0, 8'h00, AW'(40 + p), "R6");
            issue(0, 0, ~pol2, ~pol3, 1, 8'hFF, AW'(40 + p), "R6");
            rd(AW'(40 + p), "R6");
            idle(3);
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule